// File: doc/BRIEF.md
# Mailbox Dual-Port Memory

This block is a byte-wide static memory with two equal access ports, called left and right, that share one clock. Each port has its own enable, write select, address, write data and registered read data. Either port may read or write any location in the same cycle as the other. The block is used as a shared exchange area between two controllers that each service a different network. One controller writes its data into the memory, and the other controller reads it out.

The two highest addresses are doorbells. When the right port writes the second-highest address, an active-low interrupt is raised toward the left port. When the left port writes the highest address, an active-low interrupt is raised toward the right port. The receiving port acknowledges the interrupt by reading or writing its own doorbell address. A doorbell location also keeps the byte written to it, so the posted code can be read back as a message.

Top module: `mbox_dpram`

## Requirements
- R1: After reset both interrupt outputs are high (inactive) and both read-data outputs are 0.
- R2: A byte written by either port to any address is returned when either port later reads that address.
- R3: A read (enable high, write select low) presents the data on the read-data output at the next clock edge. The output keeps that value until the same port performs another read.
- R4: When one port reads an address in the same cycle that the other port writes it, the read returns the contents from before the write.
- R5: When both ports write the same address in the same cycle, the left port's byte is stored.
- R6: A right-port write to address 3FEH drives `l_irq_n` low from the next clock edge. The right-port interrupt is not affected.
- R7: A left-port access (read or write) to address 3FEH releases `l_irq_n` at the next edge. Until then, `l_irq_n` stays low.
- R8: A left-port write to address 3FFH drives `r_irq_n` low. A right-port access to 3FFH releases it.
- R9: When a doorbell is posted and acknowledged in the same cycle, the interrupt ends up asserted.
- R10: Doorbell addresses store data like ordinary locations, so the receiver reads back the posted byte.
- R11: A port whose enable is low does not write, does not change its read data, and does not acknowledge a doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low reset |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write select (1 = write) |
| l_addr | input | 10 | Left port address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port registered read data |
| l_irq_n | output | 1 | Interrupt toward left port, active low |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write select (1 = write) |
| r_addr | input | 10 | Right port address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port registered read data |
| r_irq_n | output | 1 | Interrupt toward right port, active low |

## Verification
On every cycle, the embedded assertions check the doorbell flag rules: a post sets the flag, an acknowledge without a post clears it, post beats acknowledge, and with neither the flag holds. They also check that a same-address double write stores the left byte. Other behaviours are shown only by the bench's scenarios compared against its reference model. These are cross-port data visibility, read-before-write ordering, read-data hold, the effect of a low enable, and reading back a posted doorbell code.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_AW = 10;
    localparam int unsigned MBX_DW = 8;

    typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

    // doorbell address owned by the receiving side: left gets top-1, right gets top
    function automatic int unsigned bell_addr(int unsigned aw, side_e rcv);
        return (rcv == SIDE_L) ? ((1 << aw) - 2) : ((1 << aw) - 1);
    endfunction

    typedef struct packed {
        logic pend;
    } bell_st_t;
endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] l_rd;
        logic [DATA_W-1:0] r_rd;
    } rd_st_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_st_t st_d, st_q;
    logic   l_wr, r_wr;

    assign l_wr = l_ce && l_we;
    assign r_wr = r_ce && r_we;

    always_comb begin
        st_d = st_q;
        if (l_ce && !l_we) st_d.l_rd = mem[l_addr];
        if (r_ce && !r_we) st_d.r_rd = mem[r_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // right first, left last: on a shared address the left byte lands
    always_ff @(posedge clk) begin
        if (r_wr) mem[r_addr] <= r_wdata;
        if (l_wr) mem[l_addr] <= l_wdata;
    end

    assign l_rdata = st_q.l_rd;
    assign r_rdata = st_q.r_rd;

    // R5
    left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && r_wr && l_addr == r_addr) |=> (mem[$past(l_addr)] == $past(l_wdata)));
endmodule

// File: rtl/dpr_bell.sv
module dpr_bell #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned SLOT   = 1022
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_ce,
    input  logic              post_we,
    input  logic [ADDR_W-1:0] post_addr,
    input  logic              ack_ce,
    input  logic [ADDR_W-1:0] ack_addr,
    output logic              irq_n
);
    import mbx_pkg::*;

    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT);

    bell_st_t st_d, st_q;
    logic     post_hit, ack_hit;

    assign post_hit = post_ce && post_we && (post_addr == SLOT_A);
    assign ack_hit  = ack_ce && (ack_addr == SLOT_A);

    always_comb begin
        st_d = st_q;
        if (post_hit)     st_d.pend = 1'b1;
        else if (ack_hit) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_n = ~st_q.pend;

    // R6
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_hit |=> !irq_n);
    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !post_hit) |=> irq_n);
    // R9
    post_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && post_hit) |=> !irq_n);
    // R11
    bell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_hit && !post_hit) |=> $stable(irq_n));
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
    parameter int unsigned ADDR_W = mbx_pkg::MBX_AW,
    parameter int unsigned DATA_W = mbx_pkg::MBX_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    import mbx_pkg::*;

    localparam int unsigned NSIDE = 2;

    logic              p_ce   [NSIDE];
    logic              p_we   [NSIDE];
    logic [ADDR_W-1:0] p_addr [NSIDE];
    logic              irq_n  [NSIDE];

    assign p_ce[0]   = l_ce;
    assign p_we[0]   = l_we;
    assign p_addr[0] = l_addr;
    assign p_ce[1]   = r_ce;
    assign p_we[1]   = r_we;
    assign p_addr[1] = r_addr;

    dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    // side g receives; the opposite side posts
    for (genvar g = 0; g < NSIDE; g++) begin : g_bell
        dpr_bell #(
            .ADDR_W(ADDR_W),
            .SLOT  (bell_addr(ADDR_W, side_e'(g)))
        ) u_bell (
            .clk(clk), .rst_n(rst_n),
            .post_ce(p_ce[NSIDE-1-g]), .post_we(p_we[NSIDE-1-g]), .post_addr(p_addr[NSIDE-1-g]),
            .ack_ce(p_ce[g]), .ack_addr(p_addr[g]),
            .irq_n(irq_n[g])
        );
    end

    assign l_irq_n = irq_n[0];
    assign r_irq_n = irq_n[1];
endmodule

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 1024;
    localparam logic [9:0] BELL_L = 10'h3FE;
    localparam logic [9:0] BELL_R = 10'h3FF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
    logic [9:0] l_addr = 0, r_addr = 0;
    logic [7:0] l_wdata = 0, r_wdata = 0;
    logic [7:0] l_rdata, r_rdata;
    logic       l_irq_n, r_irq_n;

    int vec = 0, bad = 0;
    bit done = 0;

    // reference model
    int mdl_mem [DEPTH];
    int exp_lrd = 0, exp_rrd = 0;   // -1 = unknown contents
    bit exp_lpend = 0, exp_rpend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_dpram i_mbox_dpram (
        .clk(clk), .rst_n(rst_n),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        if (exp_lrd >= 0) cmp(tag, "l_rdata", int'(l_rdata), exp_lrd);
        if (exp_rrd >= 0) cmp(tag, "r_rdata", int'(r_rdata), exp_rrd);
        cmp(tag, "l_irq_n", int'(l_irq_n), int'(!exp_lpend));
        cmp(tag, "r_irq_n", int'(r_irq_n), int'(!exp_rpend));
    endtask

    // called right after a falling edge; applies one cycle and compares at the next falling edge
    task automatic cyc(string tag,
                       bit lc, bit lw, logic [9:0] la, logic [7:0] ld,
                       bit rc, bit rw, logic [9:0] ra, logic [7:0] rd);
        bit sl, cl, sr, cr;
        l_ce = lc; l_we = lw; l_addr = la; l_wdata = ld;
        r_ce = rc; r_we = rw; r_addr = ra; r_wdata = rd;
        if (lc && !lw) exp_lrd = mdl_mem[la];
        if (rc && !rw) exp_rrd = mdl_mem[ra];
        if (rc && rw) mdl_mem[ra] = int'(rd);
        if (lc && lw) mdl_mem[la] = int'(ld);
        sl = rc && rw && ra == BELL_L;
        cl = lc && la == BELL_L;
        sr = lc && lw && la == BELL_R;
        cr = rc && ra == BELL_R;
        if (sl) exp_lpend = 1; else if (cl) exp_lpend = 0;
        if (sr) exp_rpend = 1; else if (cr) exp_rpend = 0;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl_mem[i] = -1;
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp("R1", "l_rdata", int'(l_rdata), 0);
        cmp("R1", "r_rdata", int'(r_rdata), 0);
        cmp("R1", "l_irq_n", int'(l_irq_n), 1);
        cmp("R1", "r_irq_n", int'(r_irq_n), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 left writes, right reads; right writes, left reads
        for (int i = 0; i < 32; i++)
            cyc("R2", 1, 1, 10'(i * 31), 8'(i * 7 + 3), 1, 1, 10'(500 + i), 8'(255 - i));
        for (int i = 0; i < 32; i++)
            cyc("R2", 1, 0, 10'(500 + i), 0, 1, 0, 10'(i * 31), 0);

        // R3 hold read data across idle and write cycles
        idle("R3");
        idle("R3");
        cyc("R3", 1, 1, 10'd40, 8'h5A, 1, 1, 10'd41, 8'hA5);
        cyc("R3", 1, 0, 10'd41, 0, 1, 0, 10'd40, 0);

        // R4 read-before-write across ports
        cyc("R4", 1, 1, 10'd5, 8'h11, 0, 0, 0, 0);
        cyc("R4", 1, 1, 10'd5, 8'h22, 1, 0, 10'd5, 0);
        cyc("R4", 1, 0, 10'd5, 0, 1, 1, 10'd5, 8'h33);
        cyc("R4", 1, 0, 10'd5, 0, 1, 0, 10'd5, 0);

        // R5 simultaneous write, left wins
        cyc("R5", 1, 1, 10'd7, 8'hC3, 1, 1, 10'd7, 8'h3C);
        cyc("R5", 1, 0, 10'd7, 0, 1, 0, 10'd7, 0);

        // R6 right posts to left
        cyc("R6", 0, 0, 0, 0, 1, 1, BELL_L, 8'h00);
        idle("R6");
        idle("R6");
        // R7 R10 left reads posted code and acknowledges
        cyc("R7", 1, 0, BELL_L, 0, 0, 0, 0, 0);
        idle("R7");

        // R8 left posts to right; right acknowledges by reading
        cyc("R8", 1, 1, BELL_R, 8'hFF, 0, 0, 0, 0);
        idle("R8");
        cyc("R10", 0, 0, 0, 0, 1, 0, BELL_R, 0);

        // R7 acknowledge by write
        cyc("R7", 0, 0, 0, 0, 1, 1, BELL_L, 8'h44);
        cyc("R7", 1, 1, BELL_L, 8'h45, 0, 0, 0, 0);

        // R9 post and ack in the same cycle, then clear
        cyc("R9", 1, 0, BELL_L, 0, 1, 1, BELL_L, 8'h66);
        idle("R9");
        cyc("R9", 1, 1, BELL_R, 8'h77, 1, 0, BELL_R, 0);
        cyc("R9", 1, 0, BELL_L, 0, 1, 0, BELL_R, 0);

        // R11 disabled ports: no write, no read update, no ack
        cyc("R11", 0, 0, 0, 0, 1, 1, BELL_L, 8'h12);
        cyc("R11", 0, 1, BELL_L, 8'h99, 0, 0, 0, 0);
        cyc("R11", 0, 1, 10'd7, 8'h99, 0, 1, 10'd7, 8'h98);
        cyc("R11", 1, 0, 10'd7, 0, 1, 0, BELL_L, 0);
        cyc("R11", 1, 0, BELL_L, 0, 0, 0, 0, 0);

        // mixed traffic, biased toward doorbells and a small window
        for (int n = 0; n < 3000; n++) begin
            logic [9:0] la, ra;
            la = ($urandom % 4 == 0) ? 10'(10'h3FE + $urandom % 2) : 10'($urandom % 16);
            ra = ($urandom % 4 == 0) ? 10'(10'h3FE + $urandom % 2) : 10'($urandom % 16);
            cyc("R2", 1'($urandom), 1'($urandom), la, 8'($urandom),
                      1'($urandom), 1'($urandom), ra, 8'($urandom));
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule